// File: doc/BRIEF.md
# Interrupt Summary Aggregator

This block gathers interrupt requests from six sub-units (four receive ports and two transmit ports) into one summary status register and one interrupt output pin. Each sub-unit holds sticky event flags, which are set by one-cycle event pulses on its inputs. A receive port has three event registers and a transmit port has one. A source counts as pending while any of its flags is set. Software clears a pending source only by reading the event registers of that source. The summary status register is read-only and reading it has no side effect.

A per-source enable register selects which pending sources count toward a global pending flag, held in the top bit of the summary status register. A separate control register holds a master output enable. The master enable gates only the interrupt pin and never the global flag. All access goes through a plain register bus. A read strobe returns its data one cycle later with a valid flag. A write completes in the cycle it is presented. Reads and writes use plain strobes and have no back-pressure: the block accepts every access in the cycle it is presented.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the enable register, the master enable, every event flag, the summary status and `irq_o` are all 0.
- R2: The enable register at address 0x00 is read/write. Bits 0–3 enable receive ports 0–3 and bits 4–5 enable transmit ports 0–1. A write to bits 6–7 is ignored, and those bits read as 0.
- R3: The summary status register at address 0x01 is read-only. Bit i (bits 0–3 for receive ports, bits 4–5 for transmit ports) is 1 while that source has any flag set. Bit 6 reads 0. Bit 7 is 1 when some source is both pending and enabled, whatever the master enable holds. Writes to this register are ignored.
- R4: The control register at address 0x02 holds the master enable in bit 0. Its other bits read as 0.
- R5: `irq_o` is 1 exactly when the global flag (status bit 7) is 1 and the master enable is 1.
- R6: Receive port p owns three event registers at addresses 0x10+4p+k, with k = 0..2. Its status bit is the OR of all flags in those three registers.
- R7: Transmit port t owns one event register at address 0x20+t, and its status bit is bit 4+t.
- R8: An event pulse on bit b of an event register sets flag b at the next clock edge. The flag then stays set until that register is read.
- R9: A read of an event register returns its flags and clears them. A flag whose event pulse arrives in the same cycle as the read stays set.
- R10: A read of the enable, status or control register changes no flag. A read of an unmapped address returns 0. Writes to event registers are ignored.
- R11: `rvalid_o` is 1 in the cycle after each read strobe, and `rdata_o` holds the value at that time. When no read is returned, `rvalid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid with `rvalid_o` |
| rvalid_o | output | 1 | Read data valid, one cycle after `rd_en_i` |
| rx_evt_i | input | 96 | Receive event pulses; bit (3p+k)*8+b is port p, register k, flag b |
| tx_evt_i | input | 16 | Transmit event pulses; bit 8t+b is port t, flag b |
| irq_o | output | 1 | Active-high interrupt output |

## Verification
The assertions assume the host never raises the read strobe and the write strobe in the same cycle. They also assume that event inputs are single-cycle pulses sampled on the clock edge, with no ordering rule between events and reads. The stimulus applies each access alone in its cycle. It draws events at several densities, including pulses that land in the same cycle as the clearing read of their own register. It also changes the enables and the master enable while sources are pending, so that every mix of gating is reached.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int AW         = 8;
  localparam int DW         = 8;
  localparam int NRX        = 4;
  localparam int NTX        = 2;
  localparam int NSRC       = NRX + NTX;
  localparam int RX_REGS    = 3;
  localparam int RX_STRIDE  = 4;
  localparam int ADDR_EN    = 'h00;
  localparam int ADDR_STS   = 'h01;
  localparam int ADDR_CTL   = 'h02;
  localparam int RX_BASE    = 'h10;
  localparam int TX_BASE    = 'h20;

  function automatic int rx_reg_addr(int port, int idx);
    return RX_BASE + port * RX_STRIDE + idx;
  endfunction

  function automatic int tx_reg_addr(int port);
    return TX_BASE + port;
  endfunction
endpackage

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     flags_q <= '0;
    else if (clr_i) flags_q <= evt_i;
    else            flags_q <= flags_q | evt_i;
  end

  assign flags_o = flags_q;

  // R8: a pulse always leaves its flag set
  p_evt_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));
  // R8: without a clearing read no flag drops
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  // R9: a clearing read keeps only same-cycle events
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (flags_q == $past(evt_i)));
endmodule

// File: rtl/evt_source.sv
module evt_source #(
  parameter int AW    = 8,
  parameter int W     = 8,
  parameter int NREG  = 1,
  parameter int BASE  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG*W-1:0] evt_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     addr_i,
  output logic              pend_o,
  output logic [W-1:0]      rdata_o
);
  logic [NREG-1:0]      hit;
  logic [W-1:0]         flags [NREG];
  logic [NREG-1:0]      any;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    localparam logic [AW-1:0] RADDR = AW'(BASE + k);
    assign hit[k] = (addr_i == RADDR);
    sticky_bank #(.W(W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (evt_i[k*W +: W]),
      .clr_i   (rd_en_i & hit[k]),
      .flags_o (flags[k])
    );
    assign any[k] = |flags[k];
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NREG; k++)
      if (hit[k]) rdata_o = rdata_o | flags[k];
  end

  assign pend_o = |any;
endmodule

// File: rtl/ctl_regs.sv
module ctl_regs #(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int NSRC = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] en_o,
  output logic [DW-1:0] ctl_o
);
  import irq_agg_pkg::*;
  localparam logic [DW-1:0] EN_MASK  = DW'((1 << NSRC) - 1);
  localparam logic [DW-1:0] CTL_MASK = DW'(1);
  localparam logic [AW-1:0] A_EN     = AW'(ADDR_EN);
  localparam logic [AW-1:0] A_CTL    = AW'(ADDR_CTL);

  logic [DW-1:0] en_q, ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      ctl_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_EN)  en_q  <= wdata_i & EN_MASK;
      if (addr_i == A_CTL) ctl_q <= wdata_i & CTL_MASK;
    end
  end

  assign en_o  = en_q;
  assign ctl_o = ctl_q;

  // R2: a write elsewhere leaves the enable register alone
  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i || addr_i != A_EN) |=> $stable(en_q));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int AW  = irq_agg_pkg::AW,
  parameter int DW  = irq_agg_pkg::DW,
  parameter int NRX = irq_agg_pkg::NRX,
  parameter int NTX = irq_agg_pkg::NTX,
  parameter int EW  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic                     rd_en_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o,
  output logic                     rvalid_o,
  input  logic [NRX*3*EW-1:0]      rx_evt_i,
  input  logic [NTX*EW-1:0]        tx_evt_i,
  output logic                     irq_o
);
  import irq_agg_pkg::*;
  localparam int NS = NRX + NTX;
  localparam logic [AW-1:0] A_EN  = AW'(ADDR_EN);
  localparam logic [AW-1:0] A_STS = AW'(ADDR_STS);
  localparam logic [AW-1:0] A_CTL = AW'(ADDR_CTL);

  logic [NS-1:0]  src_pend;
  logic [EW-1:0]  src_rdata [NS];
  logic [DW-1:0]  en_q, ctl_q;
  logic           global_pend;
  logic [DW-1:0]  sts_word, rd_next, rdata_q;
  logic           rvalid_q;

  for (genvar p = 0; p < NRX; p++) begin : g_rx
    evt_source #(.AW(AW), .W(EW), .NREG(RX_REGS), .BASE(rx_reg_addr(p, 0))) u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (rx_evt_i[p*RX_REGS*EW +: RX_REGS*EW]),
      .rd_en_i (rd_en_i),
      .addr_i  (addr_i),
      .pend_o  (src_pend[p]),
      .rdata_o (src_rdata[p])
    );
  end

  for (genvar t = 0; t < NTX; t++) begin : g_tx
    evt_source #(.AW(AW), .W(EW), .NREG(1), .BASE(tx_reg_addr(t))) u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (tx_evt_i[t*EW +: EW]),
      .rd_en_i (rd_en_i),
      .addr_i  (addr_i),
      .pend_o  (src_pend[NRX+t]),
      .rdata_o (src_rdata[NRX+t])
    );
  end

  ctl_regs #(.AW(AW), .DW(DW), .NSRC(NS)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .en_o    (en_q),
    .ctl_o   (ctl_q)
  );

  assign global_pend = |(src_pend & en_q[NS-1:0]);

  always_comb begin
    sts_word          = '0;
    sts_word[NS-1:0]  = src_pend;
    sts_word[DW-1]    = global_pend;
  end

  always_comb begin
    rd_next = '0;
    if      (addr_i == A_EN)  rd_next = en_q;
    else if (addr_i == A_STS) rd_next = sts_word;
    else if (addr_i == A_CTL) rd_next = ctl_q;
    else begin
      for (int s = 0; s < NS; s++)
        rd_next = rd_next | DW'(src_rdata[s]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= rd_next;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign irq_o    = global_pend & ctl_q[0];

  // R5: the pin never rises without the master enable
  p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ctl_q[0]);
  // R10: reading the summary register clears no pending source
  p_sts_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == A_STS) |=> ((src_pend & $past(src_pend)) == $past(src_pend)));
  // R11: each read strobe returns data on the next cycle
  p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rvalid_o);
  // R11: no stray valid
  p_no_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rvalid_o);
endmodule

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic [7:0]  rdata;
  logic        rvalid, irq;
  logic [95:0] rx_evt = '0;
  logic [15:0] tx_evt = '0;

  always #2.5 clk = ~clk;

  irq_aggregator u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .rx_evt_i(rx_evt), .tx_evt_i(tx_evt), .irq_o(irq)
  );

  // reference state
  logic [7:0] mrx [4][3];
  logic [7:0] mtx [2];
  logic [7:0] men;
  logic       mmaster;
  logic       exp_rvalid;
  logic [7:0] exp_rdata;
  string      exp_tag;
  string      phase_tag;
  int         checks = 0, fails = 0;
  bit         done = 0;

  function automatic logic [7:0] m_status();
    logic [7:0] s = '0;
    for (int p = 0; p < 4; p++)
      s[p] = |{mrx[p][0], mrx[p][1], mrx[p][2]};
    for (int t = 0; t < 2; t++) s[4+t] = |mtx[t];
    s[7] = |(s[5:0] & men[5:0]);
    return s;
  endfunction

  function automatic logic [7:0] m_read(int a);
    if (a == 0) return men;
    if (a == 1) return m_status();
    if (a == 2) return {7'd0, mmaster};
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 3; k++)
        if (a == 'h10 + 4*p + k) return mrx[p][k];
    for (int t = 0; t < 2; t++)
      if (a == 'h20 + t) return mtx[t];
    return 8'h00;
  endfunction

  function automatic string tag_of(int a);
    if (a == 0) return "R2";
    if (a == 1) return "R3";
    if (a == 2) return "R4";
    if (a >= 'h10 && a < 'h20 && (a % 4) != 3) return "R6/R9";
    if (a == 'h20 || a == 'h21) return "R7/R9";
    return "R10";
  endfunction

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, phase_tag, act, expv);
    end
  endtask

  // one clock: compare outputs, then drive and advance the model
  task automatic cyc(bit w, bit r, int a, int wd, logic [95:0] rxe, logic [15:0] txe);
    logic exp_irq;
    @(negedge clk);
    exp_irq = m_status()[7] & mmaster;
    check("R5 irq_o", irq, exp_irq);
    check("R11 rvalid_o", rvalid, exp_rvalid);
    if (exp_rvalid) check(exp_tag, rdata, exp_rdata);
    wr_en = w; rd_en = r; addr = 8'(a); wdata = 8'(wd);
    rx_evt = rxe; tx_evt = txe;
    exp_rvalid = r;
    if (r) begin exp_rdata = m_read(a); exp_tag = tag_of(a); end
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 3; k++) begin
        if (r && a == 'h10 + 4*p + k) mrx[p][k] = rxe[(p*3+k)*8 +: 8];
        else mrx[p][k] = mrx[p][k] | rxe[(p*3+k)*8 +: 8];
      end
    for (int t = 0; t < 2; t++) begin
      if (r && a == 'h20 + t) mtx[t] = txe[t*8 +: 8];
      else mtx[t] = mtx[t] | txe[t*8 +: 8];
    end
    if (w && a == 0) men = 8'(wd) & 8'h3F;
    if (w && a == 2) mmaster = wd[0];
  endtask

  function automatic logic [95:0] rx_one(int p, int k, int b);
    logic [95:0] v = '0;
    v[(p*3+k)*8 + b] = 1'b1;
    return v;
  endfunction

  function automatic logic [15:0] tx_one(int t, int b);
    logic [15:0] v = '0;
    v[t*8 + b] = 1'b1;
    return v;
  endfunction

  function automatic logic [7:0] rnd_byte(int dens);
    if (int'($urandom % 100) < dens) return 8'(1 << ($urandom % 8));
    return 8'h00;
  endfunction

  function automatic int rnd_addr();
    int sel = int'($urandom % 20);
    if (sel < 2)  return sel;
    if (sel == 2) return 2;
    if (sel < 15) return 'h10 + 4*((sel-3)/3) + ((sel-3)%3);
    if (sel < 17) return 'h20 + (sel-15);
    if (sel == 17) return 'h13;
    if (sel == 18) return 'h05;
    return 1;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 4; p++) for (int k = 0; k < 3; k++) mrx[p][k] = '0;
    mtx[0] = '0; mtx[1] = '0; men = '0; mmaster = 0;
    exp_rvalid = 0; exp_rdata = '0; exp_tag = "";
    phase_tag = "R1 reset";
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset values
    cyc(0, 1, 0, 0, '0, '0);
    cyc(0, 1, 1, 0, '0, '0);
    cyc(0, 1, 2, 0, '0, '0);
    cyc(0, 1, 'h14, 0, '0, '0);
    cyc(0, 1, 'h21, 0, '0, '0);
    phase_tag = "R2 R3 R4 writes";
    cyc(1, 0, 0, 'hFF, '0, '0);          // R2 reserved bits dropped
    cyc(0, 1, 0, 0, '0, '0);
    cyc(1, 0, 1, 'hFF, '0, '0);          // R3 status write ignored
    cyc(0, 1, 1, 0, '0, '0);
    cyc(1, 0, 2, 'hFF, '0, '0);          // R4 only bit 0 kept
    cyc(0, 1, 2, 0, '0, '0);
    phase_tag = "R5 R6 rx event";
    cyc(0, 0, 0, 0, rx_one(2, 1, 3), '0);
    cyc(0, 1, 1, 0, '0, '0);             // R10 status read keeps bit
    cyc(0, 1, 1, 0, '0, '0);
    phase_tag = "R9 same-cycle event";
    cyc(0, 1, 'h19, 0, rx_one(2, 1, 3), '0);
    cyc(0, 1, 'h19, 0, '0, '0);          // clears now
    cyc(0, 1, 1, 0, '0, '0);
    phase_tag = "R7 R3 gating";
    cyc(0, 0, 0, 0, '0, tx_one(1, 6));
    cyc(1, 0, 0, 'h0F, '0, '0);          // tx1 disabled: global 0
    cyc(0, 1, 1, 0, '0, '0);
    cyc(1, 0, 0, 'h20, '0, '0);
    cyc(1, 0, 2, 0, '0, '0);             // master off: global 1, pin 0
    cyc(0, 1, 1, 0, '0, '0);
    cyc(1, 0, 2, 1, '0, '0);
    phase_tag = "R10 ignored accesses";
    cyc(1, 0, 'h21, 0, '0, '0);          // write to event reg ignored
    cyc(0, 1, 1, 0, '0, '0);
    cyc(0, 1, 'h05, 0, '0, '0);
    cyc(0, 1, 'h21, 0, '0, '0);
    cyc(0, 1, 'h21, 0, '0, '0);

    // R8 R9 random mixes of enables, events and clearing reads
    for (int ph = 0; ph < 6; ph++) begin
      int dens = (ph == 0) ? 2 : (ph == 1) ? 10 : (ph == 2) ? 30 : (ph == 3) ? 0 : (ph == 4) ? 60 : 5;
      int rdp  = (ph == 3) ? 80 : 35;
      phase_tag = $sformatf("R8 random phase %0d", ph);
      for (int i = 0; i < 600; i++) begin
        logic [95:0] rxe;
        logic [15:0] txe;
        int sel = int'($urandom % 100);
        for (int b = 0; b < 12; b++) rxe[b*8 +: 8] = rnd_byte(dens / 4);
        for (int b = 0; b < 2; b++)  txe[b*8 +: 8] = rnd_byte(dens / 4);
        if (sel < 6)
          cyc(1, 0, ($urandom % 2) ? 0 : 2, int'($urandom % 256), rxe, txe);
        else if (sel < 6 + rdp)
          cyc(0, 1, rnd_addr(), 0, rxe, txe);
        else
          cyc(0, 0, 0, 0, rxe, txe);
      end
    end
    cyc(0, 0, 0, 0, '0, '0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule